// File: doc/BRIEF.md
# Address-Range Memory Protection Checker

This block sits beside a memory controller and decides, for every memory transaction, whether it may proceed. It holds a table of 20 programmable protection rules. Each rule names a window of 1 MiB address pages, a window of transaction IDs, the set of ports it covers, which security attributes it applies to, and whether a hit accepts or rejects the transaction. When several rules hit, the lowest-numbered one wins. When none hits, a per-port default bit decides.

Software reaches the table indirectly. It fills three staging registers (page window, ID window and rule attributes), then writes the select/command register with a rule number and a commit strobe to copy the staging set into that rule. It can also write a fetch strobe to copy a rule back into the staging set and read it there. A separate register holds the per-port default bits. The decision for a transaction is registered and comes out one cycle after the transaction is presented.

Top module: `mem_prot_chk`

## Requirements
- R1: After reset every rule is invalid, every register in the window reads 0, `dec_valid` is 0, and every transaction on ports 0 to 9 is accepted with `dec_hit` = 0.
- R2: A transaction presented with `txn_valid` = 1 at a clock edge produces `dec_valid` = 1 with its decision after that edge; with `txn_valid` = 0 the next `dec_valid` is 0.
- R3: Register offsets on `reg_addr`: 0 select/command (rule number in bits 4:0), 1 page window (first page in bits 11:0, last page in bits 23:12), 2 ID window (lowest ID in bits 11:0, highest ID in bits 23:12), 3 attributes (security in bits 1:0, valid in bit 2, port mask in bits 12:3, reject in bit 13), 4 default (one bit per port in bits 9:0). Each reads back the written value in those fields and 0 elsewhere; strobe bits read as 0.
- R4: Writing offset 0 with bit 5 set commits the staging set into the selected rule at that clock edge; the staging registers keep their values.
- R5: Writing offset 0 with bit 6 set and bit 5 clear loads the selected rule into the staging registers, readable from the next cycle.
- R6: A commit or fetch naming a rule number of 20 or more changes neither the table nor the staging registers.
- R7: A rule hits when it is valid, the port's bit is set in its mask, address bits 31:20 lie between the first and last page inclusive, and the ID lies between the lowest and highest ID inclusive.
- R8: Security bit 0 lets a rule hit secure transactions (`txn_secure` = 1); bit 1 lets it hit non-secure ones.
- R9: When several rules hit, the lowest-numbered decides; `dec_hit` = 1 and `dec_rule` gives its number.
- R10: With no hit, default bit p decides for port p (0 accept, 1 reject); a port number of 10 or more never hits and is always rejected.
- R11: A winning rule with reject bit 0 accepts the transaction and with reject bit 1 rejects it.
- R12: Committing all-zero staging registers to a rule makes it invalid so it no longer hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_addr | input | 32 | Transaction byte address |
| txn_id | input | 12 | Transaction ID |
| txn_port | input | 4 | Port number of the transaction |
| txn_secure | input | 1 | 1 for a secure transaction, 0 for non-secure |
| dec_valid | output | 1 | Decision valid (one cycle after `txn_valid`) |
| dec_reject | output | 1 | 1 rejects, 0 accepts |
| dec_hit | output | 1 | A rule decided (0: default decided) |
| dec_rule | output | 5 | Number of the deciding rule when `dec_hit` is 1 |

## Verification
The decision for a transaction is due exactly one clock after it is presented, so the bench drives a transaction on a falling edge and reads `dec_valid`, `dec_reject`, `dec_hit` and `dec_rule` on the following falling edge, after the single register stage has loaded. Register writes act at the rising edge that samples them: a commit is visible to the very next transaction, and fetched or written staging values are read back combinationally on the falling edge after the write. Boundary pages, boundary IDs, port mask bits, security bits, overlapping rules, out-of-range rule numbers and out-of-range ports are each driven with expected values worked out from the requirements.

// File: rtl/mprot_pkg.sv
// Shared widths, register offsets and the rule record for the protection checker.
package mprot_pkg;
    localparam int PAGE_W   = 12;   // address page number width (1 MiB pages)
    localparam int ID_W     = 12;   // transaction ID width
    localparam int NPORT    = 10;   // number of ports with a mask/default bit
    localparam int PORT_W   = 4;    // width of the port number input
    localparam int SEC_W    = 2;    // security permission bits
    localparam int IDX_W    = 5;    // rule number field width in the command register
    localparam int REG_W    = 32;   // register data width
    localparam int REGA_W   = 3;    // register offset width

    localparam int CMD_COMMIT_BIT = 5;
    localparam int CMD_FETCH_BIT  = 6;

    localparam int ATTR_VALID_BIT = SEC_W;
    localparam int ATTR_PMASK_LSB = SEC_W + 1;
    localparam int ATTR_DENY_BIT  = SEC_W + 1 + NPORT;

    typedef enum logic [REGA_W-1:0] {
        REG_SEL   = 3'd0,
        REG_RANGE = 3'd1,
        REG_IDWIN = 3'd2,
        REG_ATTR  = 3'd3,
        REG_DFLT  = 3'd4
    } reg_off_e;

    typedef struct packed {
        logic [PAGE_W-1:0] pg_hi;
        logic [PAGE_W-1:0] pg_lo;
        logic [ID_W-1:0]   id_hi;
        logic [ID_W-1:0]   id_lo;
        logic              deny;
        logic [NPORT-1:0]  pmask;
        logic              valid;
        logic [SEC_W-1:0]  sec;
    } rule_t;
endpackage

// File: rtl/mprot_regwin.sv
// Register window: staging set, select/command decode, default bits, read mux.
// Assumes one register access per cycle; reads are combinational on reg_addr.
module mprot_regwin
    import mprot_pkg::*;
#(
    parameter int NUM_RULES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REGA_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  rule_t             rd_rule_i,
    output logic [IDX_W-1:0]  acc_idx_o,
    output logic              commit_en_o,
    output rule_t             commit_rule_o,
    output logic [NPORT-1:0]  dflt_o
);
    logic [IDX_W-1:0] sel_q;
    rule_t            stg_q;
    logic [NPORT-1:0] dflt_q;
    logic             cmd_wr;
    logic             idx_ok;
    logic             fetch_en;

    // Decode a command write and check the rule number against the table size.
    always_comb begin
        cmd_wr      = reg_wr && (reg_addr == REG_SEL);
        acc_idx_o   = reg_wdata[IDX_W-1:0];
        idx_ok      = (32'(acc_idx_o) < NUM_RULES);
        commit_en_o = cmd_wr && reg_wdata[CMD_COMMIT_BIT] && idx_ok;
        fetch_en    = cmd_wr && reg_wdata[CMD_FETCH_BIT] && !reg_wdata[CMD_COMMIT_BIT] && idx_ok;
    end

    // Update select, staging and default registers from writes and fetches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            stg_q  <= '0;
            dflt_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                REG_SEL: begin
                    sel_q <= reg_wdata[IDX_W-1:0];
                    if (fetch_en) stg_q <= rd_rule_i;
                end
                REG_RANGE: begin
                    stg_q.pg_lo <= reg_wdata[PAGE_W-1:0];
                    stg_q.pg_hi <= reg_wdata[2*PAGE_W-1:PAGE_W];
                end
                REG_IDWIN: begin
                    stg_q.id_lo <= reg_wdata[ID_W-1:0];
                    stg_q.id_hi <= reg_wdata[2*ID_W-1:ID_W];
                end
                REG_ATTR: begin
                    stg_q.sec   <= reg_wdata[SEC_W-1:0];
                    stg_q.valid <= reg_wdata[ATTR_VALID_BIT];
                    stg_q.pmask <= reg_wdata[ATTR_PMASK_LSB +: NPORT];
                    stg_q.deny  <= reg_wdata[ATTR_DENY_BIT];
                end
                REG_DFLT: dflt_q <= reg_wdata[NPORT-1:0];
                default: ;
            endcase
        end
    end

    // Present the register selected by reg_addr.
    always_comb begin
        case (reg_addr)
            REG_SEL:   reg_rdata = REG_W'(sel_q);
            REG_RANGE: reg_rdata = REG_W'({stg_q.pg_hi, stg_q.pg_lo});
            REG_IDWIN: reg_rdata = REG_W'({stg_q.id_hi, stg_q.id_lo});
            REG_ATTR:  reg_rdata = REG_W'({stg_q.deny, stg_q.pmask, stg_q.valid, stg_q.sec});
            REG_DFLT:  reg_rdata = REG_W'(dflt_q);
            default:   reg_rdata = '0;
        endcase
    end

    assign commit_rule_o = stg_q;
    assign dflt_o        = dflt_q;

    // R5
    fetch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |=> (stg_q == $past(rd_rule_i)));
endmodule

// File: rtl/mprot_rule_table.sv
// Rule storage: one register per rule, written by commit, read by index.
// Assumes the commit index is already checked against NUM_RULES.
module mprot_rule_table
    import mprot_pkg::*;
#(
    parameter int NUM_RULES = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_en_i,
    input  logic [IDX_W-1:0] acc_idx_i,
    input  rule_t            commit_rule_i,
    output rule_t            rd_rule_o,
    output rule_t            rules_o [NUM_RULES]
);
    rule_t rules_q [NUM_RULES];

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        // Hold one rule; cleared by reset, replaced on a commit naming it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rules_q[g] <= '0;
            else if (commit_en_i && (acc_idx_i == IDX_W'(g)))
                rules_q[g] <= commit_rule_i;
        end

        assign rules_o[g] = rules_q[g];

        // R4
        commit_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_en_i && (acc_idx_i == IDX_W'(g))) |=> (rules_q[g] == $past(commit_rule_i)));
    end

    // Select the rule named by the access index for a fetch.
    always_comb begin
        rd_rule_o = '0;
        for (int i = 0; i < NUM_RULES; i++)
            if (acc_idx_i == IDX_W'(i)) rd_rule_o = rules_q[i];
    end
endmodule

// File: rtl/mprot_decide.sv
// Match every rule against the transaction, pick the lowest-numbered hit,
// fall back to the per-port default, and register the decision.
// Assumes the rule array is stable for the cycle the transaction is sampled.
module mprot_decide
    import mprot_pkg::*;
#(
    parameter int NUM_RULES = 20,
    parameter int ADDR_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rule_t             rules_i [NUM_RULES],
    input  logic [NPORT-1:0]  dflt_i,
    input  logic              txn_valid,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [ID_W-1:0]   txn_id,
    input  logic [PORT_W-1:0] txn_port,
    input  logic              txn_secure,
    output logic              dec_valid,
    output logic              dec_reject,
    output logic              dec_hit,
    output logic [IDX_W-1:0]  dec_rule
);
    logic [PAGE_W-1:0]    page;
    logic                 port_ok;
    logic [NUM_RULES-1:0] hit_vec;
    logic                 win_found;
    logic [IDX_W-1:0]     win_idx;
    logic                 win_deny;
    logic                 dflt_rej;
    logic [NPORT-1:0]     dflt_sh;

    assign page    = txn_addr[ADDR_W-1 -: PAGE_W];
    assign port_ok = (32'(txn_port) < NPORT);

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_match
        logic [NPORT-1:0] pm_sh;
        logic             sec_ok;
        // Evaluate all hit conditions of one rule.
        always_comb begin
            pm_sh      = rules_i[g].pmask >> txn_port;
            sec_ok     = txn_secure ? rules_i[g].sec[0] : rules_i[g].sec[1];
            hit_vec[g] = rules_i[g].valid && port_ok && pm_sh[0] && sec_ok
                      && (page >= rules_i[g].pg_lo) && (page <= rules_i[g].pg_hi)
                      && (txn_id >= rules_i[g].id_lo) && (txn_id <= rules_i[g].id_hi);
        end
    end

    // Lowest-numbered hit wins; scan from the top so lower indices overwrite.
    always_comb begin
        win_found = 1'b0;
        win_idx   = '0;
        win_deny  = 1'b0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                win_found = 1'b1;
                win_idx   = IDX_W'(i);
                win_deny  = rules_i[i].deny;
            end
        end
    end

    // Default response for the port; unknown ports are rejected.
    always_comb begin
        dflt_sh  = dflt_i >> txn_port;
        dflt_rej = port_ok ? dflt_sh[0] : 1'b1;
    end

    // Register the decision one cycle after the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_reject <= 1'b0;
            dec_hit    <= 1'b0;
            dec_rule   <= '0;
        end else begin
            dec_valid  <= txn_valid;
            dec_reject <= txn_valid && (win_found ? win_deny : dflt_rej);
            dec_hit    <= txn_valid && win_found;
            dec_rule   <= (txn_valid && win_found) ? win_idx : '0;
        end
    end

    // R2
    valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> dec_valid);
    // R2
    idle_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |=> !dec_valid);
    // R10
    default_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && (hit_vec == '0)) |=> (!dec_hit && (dec_reject == $past(dflt_rej))));
    // R9
    rule0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && hit_vec[0]) |=> (dec_hit && (dec_rule == '0)));
endmodule

// File: rtl/mem_prot_chk.sv
// Top: address-range memory protection checker with indirect rule access.
// Assumes register accesses and transactions share one clock domain.
module mem_prot_chk
    import mprot_pkg::*;
#(
    parameter int NUM_RULES = 20,
    parameter int ADDR_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              txn_valid,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [11:0]       txn_id,
    input  logic [3:0]        txn_port,
    input  logic              txn_secure,
    output logic              dec_valid,
    output logic              dec_reject,
    output logic              dec_hit,
    output logic [4:0]        dec_rule
);
    rule_t            rd_rule;
    rule_t            commit_rule;
    rule_t            rules [NUM_RULES];
    logic [IDX_W-1:0] acc_idx;
    logic             commit_en;
    logic [NPORT-1:0] dflt;

    mprot_regwin #(.NUM_RULES(NUM_RULES)) regwin_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .rd_rule_i     (rd_rule),
        .acc_idx_o     (acc_idx),
        .commit_en_o   (commit_en),
        .commit_rule_o (commit_rule),
        .dflt_o        (dflt)
    );

    mprot_rule_table #(.NUM_RULES(NUM_RULES)) table_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_en_i   (commit_en),
        .acc_idx_i     (acc_idx),
        .commit_rule_i (commit_rule),
        .rd_rule_o     (rd_rule),
        .rules_o       (rules)
    );

    mprot_decide #(.NUM_RULES(NUM_RULES), .ADDR_W(ADDR_W)) decide_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rules_i    (rules),
        .dflt_i     (dflt),
        .txn_valid  (txn_valid),
        .txn_addr   (txn_addr),
        .txn_id     (txn_id),
        .txn_port   (txn_port),
        .txn_secure (txn_secure),
        .dec_valid  (dec_valid),
        .dec_reject (dec_reject),
        .dec_hit    (dec_hit),
        .dec_rule   (dec_rule)
    );
endmodule

// File: tb/mem_prot_chk_tb_top.sv
// Directed bench for mem_prot_chk: one task per scenario.
module mem_prot_chk_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        txn_valid = 1'b0;
    logic [31:0] txn_addr = '0;
    logic [11:0] txn_id = '0;
    logic [3:0]  txn_port = '0;
    logic        txn_secure = 1'b0;
    logic        dec_valid, dec_reject, dec_hit;
    logic [4:0]  dec_rule;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mem_prot_chk dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txn_valid(txn_valid),
        .txn_addr(txn_addr), .txn_id(txn_id), .txn_port(txn_port),
        .txn_secure(txn_secure), .dec_valid(dec_valid), .dec_reject(dec_reject),
        .dec_hit(dec_hit), .dec_rule(dec_rule)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Stage and commit one rule; attr uses sec 1:0, valid 2, mask 12:3, reject 13.
    task automatic put_rule(input int idx, input logic [11:0] plo, input logic [11:0] phi,
                            input logic [11:0] ilo, input logic [11:0] ihi, input logic [31:0] attr);
        wr_reg(3'd1, {8'h0, phi, plo});
        wr_reg(3'd2, {8'h0, ihi, ilo});
        wr_reg(3'd3, attr);
        wr_reg(3'd0, 32'(idx) | 32'h20);
    endtask

    // Drive a transaction and return the decision one cycle later: {valid,reject,hit,rule}.
    task automatic txn(input logic [11:0] pg, input logic [11:0] id, input logic [3:0] port,
                       input logic sec, input logic [19:0] off, output logic [7:0] res);
        @(negedge clk);
        txn_valid = 1'b1; txn_addr = {pg, off}; txn_id = id; txn_port = port; txn_secure = sec;
        @(negedge clk);
        txn_valid = 1'b0;
        res = {dec_valid, dec_reject, dec_hit, dec_rule};
    endtask

    function automatic logic [7:0] dres(input logic rej, input logic hit, input logic [4:0] rule);
        return {1'b1, rej, hit, rule};
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        logic [7:0] r;
        chk("R1 dec_valid after reset", 32'(dec_valid), 0);
        for (int a = 0; a < 5; a++) begin
            rd_reg(3'(a), d);
            chk("R1 register reads 0 after reset", d, 0);
        end
        txn(12'h123, 12'h055, 4'd3, 1'b1, 20'h0, r);
        chk("R1 accept with no rule", 32'(r), 32'(dres(0, 0, 0)));
        @(negedge clk);
        chk("R2 dec_valid drops when idle", 32'(dec_valid), 0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr_reg(3'd1, 32'h0123_4567); rd_reg(3'd1, d); chk("R3 page window field", d, 32'h0023_4567);
        wr_reg(3'd2, 32'hFFAB_CDEF); rd_reg(3'd2, d); chk("R3 ID window field", d, 32'h00AB_CDEF);
        wr_reg(3'd3, 32'hFFFF_FFFF); rd_reg(3'd3, d); chk("R3 attribute field", d, 32'h0000_3FFF);
        wr_reg(3'd4, 32'hFFFF_FFFF); rd_reg(3'd4, d); chk("R3 default field", d, 32'h0000_03FF);
        wr_reg(3'd4, 32'h0);
        wr_reg(3'd0, 32'h19); rd_reg(3'd0, d); chk("R3 select field", d, 32'h19);
    endtask

    task automatic t_commit_fetch;
        logic [31:0] d;
        logic [7:0] r;
        put_rule(7, 12'h010, 12'h01F, 12'd5, 12'd9, 32'h3FFF);
        rd_reg(3'd3, d); chk("R4 staging kept after commit", d, 32'h3FFF);
        rd_reg(3'd0, d); chk("R3 strobe bits read 0", d, 32'h7);
        wr_reg(3'd1, 0); wr_reg(3'd2, 0); wr_reg(3'd3, 0);
        wr_reg(3'd0, 32'h47);
        rd_reg(3'd1, d); chk("R5 fetched page window", d, 32'h0001_F010);
        rd_reg(3'd2, d); chk("R5 fetched ID window", d, 32'h0000_9005);
        rd_reg(3'd3, d); chk("R5 fetched attributes", d, 32'h3FFF);
        txn(12'h015, 12'd7, 4'd2, 1'b1, 20'h0, r);
        chk("R4 committed rule rejects", 32'(r), 32'(dres(1, 1, 7)));
    endtask

    task automatic t_bounds;
        logic [7:0] r;
        txn(12'h010, 12'd5, 4'd0, 1'b0, 20'h0, r);     chk("R7 first page lowest ID", 32'(r), 32'(dres(1, 1, 7)));
        txn(12'h01F, 12'd9, 4'd9, 1'b1, 20'hFFFFF, r); chk("R7 last page top byte highest ID", 32'(r), 32'(dres(1, 1, 7)));
        txn(12'h00F, 12'd7, 4'd2, 1'b1, 20'hFFFFF, r); chk("R7 page below window", 32'(r), 32'(dres(0, 0, 0)));
        txn(12'h020, 12'd7, 4'd2, 1'b1, 20'h0, r);     chk("R7 page above window", 32'(r), 32'(dres(0, 0, 0)));
        txn(12'h015, 12'd4, 4'd2, 1'b1, 20'h0, r);     chk("R7 ID below window", 32'(r), 32'(dres(0, 0, 0)));
        txn(12'h015, 12'd10, 4'd2, 1'b1, 20'h0, r);    chk("R7 ID above window", 32'(r), 32'(dres(0, 0, 0)));
    endtask

    task automatic t_port_sec;
        logic [7:0] r;
        put_rule(3, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 32'h2087);
        txn(12'h100, 12'd1, 4'd4, 1'b1, 20'h0, r); chk("R7 port in mask", 32'(r), 32'(dres(1, 1, 3)));
        txn(12'h100, 12'd1, 4'd5, 1'b1, 20'h0, r); chk("R7 port outside mask", 32'(r), 32'(dres(0, 0, 0)));
        put_rule(3, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 32'h2085);
        txn(12'h100, 12'd1, 4'd4, 1'b1, 20'h0, r); chk("R8 secure-only hits secure", 32'(r), 32'(dres(1, 1, 3)));
        txn(12'h100, 12'd1, 4'd4, 1'b0, 20'h0, r); chk("R8 secure-only skips non-secure", 32'(r), 32'(dres(0, 0, 0)));
        put_rule(3, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 32'h2086);
        txn(12'h100, 12'd1, 4'd4, 1'b0, 20'h0, r); chk("R8 non-secure-only hits non-secure", 32'(r), 32'(dres(1, 1, 3)));
        txn(12'h100, 12'd1, 4'd4, 1'b1, 20'h0, r); chk("R8 non-secure-only skips secure", 32'(r), 32'(dres(0, 0, 0)));
        put_rule(3, 0, 0, 0, 0, 0);
    endtask

    task automatic t_priority;
        logic [7:0] r;
        put_rule(2, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 32'h1FFF);
        txn(12'h015, 12'd7, 4'd2, 1'b1, 20'h0, r); chk("R9 R11 lower rule accepts", 32'(r), 32'(dres(0, 1, 2)));
        txn(12'h300, 12'd7, 4'd2, 1'b1, 20'h0, r); chk("R11 single accept rule", 32'(r), 32'(dres(0, 1, 2)));
        put_rule(2, 0, 0, 0, 0, 0);
        txn(12'h015, 12'd7, 4'd2, 1'b1, 20'h0, r); chk("R12 cleared rule no longer hits", 32'(r), 32'(dres(1, 1, 7)));
    endtask

    task automatic t_default;
        logic [7:0] r;
        for (int i = 0; i < 20; i++) put_rule(i, 0, 0, 0, 0, 0);
        wr_reg(3'd4, 32'h3FF);
        txn(12'h015, 12'd7, 4'd2, 1'b1, 20'h0, r); chk("R12 all cleared, default rejects", 32'(r), 32'(dres(1, 0, 0)));
        wr_reg(3'd4, 32'h001);
        txn(12'h050, 12'd0, 4'd0, 1'b0, 20'h0, r); chk("R10 default bit 0 rejects port 0", 32'(r), 32'(dres(1, 0, 0)));
        txn(12'h050, 12'd0, 4'd1, 1'b0, 20'h0, r); chk("R10 default bit 1 accepts port 1", 32'(r), 32'(dres(0, 0, 0)));
        put_rule(2, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 32'h1FFF);
        txn(12'h050, 12'd0, 4'd12, 1'b0, 20'h0, r); chk("R10 port 12 rejected", 32'(r), 32'(dres(1, 0, 0)));
        put_rule(2, 0, 0, 0, 0, 0);
    endtask

    task automatic t_bad_index;
        logic [31:0] d;
        logic [7:0] r;
        wr_reg(3'd4, 32'h3FF);
        put_rule(20, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 32'h1FFF);
        txn(12'h050, 12'd0, 4'd0, 1'b0, 20'h0, r); chk("R6 commit to rule 20 ignored", 32'(r), 32'(dres(1, 0, 0)));
        wr_reg(3'd0, 32'h55);
        rd_reg(3'd3, d); chk("R6 fetch of rule 21 ignored", d, 32'h1FFF);
        rd_reg(3'd1, d); chk("R6 fetch of rule 21 keeps window", d, 32'h00FF_F000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_commit_fetch;
        t_bounds;
        t_port_sec;
        t_priority;
        t_default;
        t_bad_index;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule